// File: doc/BRIEF.md
# Single-Bit Manipulation Unit

This block carries out one single-bit operation on an 8-bit operand byte per request. A request presents the byte, a 3-bit bit index, a 4-bit operation code and the present carry (C) and zero (Z) flags. One clock later the unit returns the possibly modified byte, a write-enable that tells the surrounding datapath whether the byte must be stored back, and the new C and Z flags. Reading and writing the byte in memory or a register file is left to the caller; the unit only supplies read-modify-write data.

The operations are forcing the selected bit high or low, toggling it, testing it into Z, copying it (or its complement) into C, writing C (or its complement) into it, and combining it (or its complement) with C by AND, OR or XOR, with the result placed in C. Only operations that change the byte raise the write-enable.

The control is a two-state machine. In `ST_IDLE` no result is presented. A request (`start_i` high) moves it to `ST_DONE` on the next edge (transition IDLE_TO_DONE). In `ST_DONE` the result is on the outputs for one cycle; a further request keeps it in `ST_DONE` with the new result (DONE_TO_DONE), otherwise it returns to `ST_IDLE` (DONE_TO_IDLE). With no request in `ST_IDLE` it stays there (IDLE_TO_IDLE).

Top module: `bitop_unit`

## Requirements
- R1: The bit index selects exactly one bit of the byte: index k addresses bit k, with bit 0 the least significant.
- R2: Operation codes 0 (force high), 1 (force low) and 2 (toggle) return the byte with only the selected bit forced to 1, forced to 0 or inverted, raise the write-enable, and leave C and Z as they came in.
- R3: Code 3 (test) returns Z = 1 when the selected bit is 0 and Z = 0 when it is 1, keeps C, returns the byte unchanged and does not raise the write-enable.
- R4: Codes 4 (load) and 5 (inverted load) set C to the selected bit or to its complement, keep Z and the byte, and do not raise the write-enable.
- R5: Codes 6 (store) and 7 (inverted store) return the byte with the selected bit replaced by C or by NOT C, all other bits kept, raise the write-enable, and keep C and Z.
- R6: Codes 8/9 (AND, inverted AND), 10/11 (OR, inverted OR) and 12/13 (XOR, inverted XOR) set C to the selected bit, or for the odd codes its complement, combined with the incoming C; Z and the byte are kept and the write-enable stays low.
- R7: Codes 14 and 15 have no effect: the byte, C and Z come back unchanged and the write-enable stays low.
- R8: The result appears on the outputs, with `res_valid_o` high, in the cycle after the request edge; without a request `res_valid_o` and `wr_en_o` are low in the following cycle and the byte and flag outputs hold their last values. Back-to-back requests give back-to-back results.
- R9: During and right after reset `res_valid_o`, `wr_en_o`, `data_o`, `c_o` and `z_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request: operands below are taken at this edge |
| op_i | input | 4 | Operation code (0 to 15, see requirements) |
| bit_idx_i | input | 3 | Index of the selected bit |
| data_i | input | 8 | Operand byte |
| c_i | input | 1 | Incoming carry flag |
| z_i | input | 1 | Incoming zero flag |
| res_valid_o | output | 1 | Result presented this cycle |
| data_o | output | 8 | Result byte |
| wr_en_o | output | 1 | Result byte must be written back |
| c_o | output | 1 | New carry flag |
| z_o | output | 1 | New zero flag |

## Verification
The hardest case to reach from the ports is the hold behaviour of R8 combined with the write-enable: a result whose byte differs from the input must stay on `data_o` through an idle cycle while `wr_en_o` drops, and then a back-to-back pair must replace it without a gap. The stimulus leaves an idle cycle before every request and checks the held byte there, and adds directed back-to-back pairs that mix a writing operation with a non-writing one. Random codes, indices, bytes and flags cover the carry-combining variants with both carry values, and directed cases sweep every index with bytes 0x00 and 0xFF.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    typedef enum logic [3:0] {
        OP_SET   = 4'd0,
        OP_CLR   = 4'd1,
        OP_INV   = 4'd2,
        OP_TEST  = 4'd3,
        OP_LDC   = 4'd4,
        OP_LDCN  = 4'd5,
        OP_STC   = 4'd6,
        OP_STCN  = 4'd7,
        OP_AND   = 4'd8,
        OP_ANDN  = 4'd9,
        OP_OR    = 4'd10,
        OP_ORN   = 4'd11,
        OP_XOR   = 4'd12,
        OP_XORN  = 4'd13,
        OP_RSV0  = 4'd14,
        OP_RSV1  = 4'd15
    } bitop_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } state_e;

endpackage

// File: rtl/bitop_mask.sv
module bitop_mask #(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [IDX_W-1:0]  idx_i,
    output logic [DATA_W-1:0] mask_o
);

    for (genvar g = 0; g < DATA_W; g++) begin : g_sel
        assign mask_o[g] = (idx_i == IDX_W'(g));
    end

endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
    import bitop_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  bitop_e            op_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [DATA_W-1:0] mask_i,
    input  logic              c_i,
    input  logic              z_i,
    output logic [DATA_W-1:0] data_o,
    output logic              wr_o,
    output logic              c_o,
    output logic              z_o
);

    logic              sel_bit;
    logic [DATA_W-1:0] carry_fill;

    assign sel_bit    = |(data_i & mask_i);
    assign carry_fill = {DATA_W{1'b1}} & mask_i;

    always_comb begin
        data_o = data_i;
        wr_o   = 1'b0;
        c_o    = c_i;
        z_o    = z_i;
        unique case (op_i)
            OP_SET: begin
                data_o = data_i | mask_i;
                wr_o   = 1'b1;
            end
            OP_CLR: begin
                data_o = data_i & ~mask_i;
                wr_o   = 1'b1;
            end
            OP_INV: begin
                data_o = data_i ^ mask_i;
                wr_o   = 1'b1;
            end
            OP_TEST: z_o = ~sel_bit;
            OP_LDC:  c_o = sel_bit;
            OP_LDCN: c_o = ~sel_bit;
            OP_STC: begin
                data_o = (data_i & ~mask_i) | (c_i ? carry_fill : '0);
                wr_o   = 1'b1;
            end
            OP_STCN: begin
                data_o = (data_i & ~mask_i) | (c_i ? '0 : carry_fill);
                wr_o   = 1'b1;
            end
            OP_AND:  c_o = sel_bit & c_i;
            OP_ANDN: c_o = ~sel_bit & c_i;
            OP_OR:   c_o = sel_bit | c_i;
            OP_ORN:  c_o = ~sel_bit | c_i;
            OP_XOR:  c_o = sel_bit ^ c_i;
            OP_XORN: c_o = ~sel_bit ^ c_i;
            OP_RSV0, OP_RSV1: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/bitop_ctrl.sv
module bitop_ctrl
    import bitop_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] data_nxt_i,
    input  logic              wr_nxt_i,
    input  logic              c_nxt_i,
    input  logic              z_nxt_i,
    output logic              res_valid_o,
    output logic [DATA_W-1:0] data_o,
    output logic              wr_en_o,
    output logic              c_o,
    output logic              z_o
);

    state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = start_i ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = start_i ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_o  <= '0;
            wr_en_o <= 1'b0;
            c_o     <= 1'b0;
            z_o     <= 1'b0;
        end else if (start_i) begin
            data_o  <= data_nxt_i;
            wr_en_o <= wr_nxt_i;
            c_o     <= c_nxt_i;
            z_o     <= z_nxt_i;
        end else begin
            wr_en_o <= 1'b0;
        end
    end

    assign res_valid_o = (state_q == ST_DONE);

    AST_REQ_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> res_valid_o);                                   // R8
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (!res_valid_o && !wr_en_o));                   // R8
    AST_IDLE_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> ($stable(data_o) && $stable(c_o) && $stable(z_o))); // R8
    AST_WR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> res_valid_o);                                   // R2

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [3:0]        op_i,
    input  logic [IDX_W-1:0]  bit_idx_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              c_i,
    input  logic              z_i,
    output logic              res_valid_o,
    output logic [DATA_W-1:0] data_o,
    output logic              wr_en_o,
    output logic              c_o,
    output logic              z_o
);

    logic [DATA_W-1:0] mask_w;
    logic [DATA_W-1:0] data_nxt;
    logic              wr_nxt;
    logic              c_nxt;
    logic              z_nxt;
    bitop_e            op_w;

    assign op_w = bitop_e'(op_i);

    bitop_mask #(.DATA_W(DATA_W)) u_mask (
        .idx_i  (bit_idx_i),
        .mask_o (mask_w)
    );

    bitop_alu #(.DATA_W(DATA_W)) u_alu (
        .op_i   (op_w),
        .data_i (data_i),
        .mask_i (mask_w),
        .c_i    (c_i),
        .z_i    (z_i),
        .data_o (data_nxt),
        .wr_o   (wr_nxt),
        .c_o    (c_nxt),
        .z_o    (z_nxt)
    );

    bitop_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .data_nxt_i  (data_nxt),
        .wr_nxt_i    (wr_nxt),
        .c_nxt_i     (c_nxt),
        .z_nxt_i     (z_nxt),
        .res_valid_o (res_valid_o),
        .data_o      (data_o),
        .wr_en_o     (wr_en_o),
        .c_o         (c_o),
        .z_o         (z_o)
    );

    AST_MASK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mask_w) == 1);                                   // R1
    AST_TEST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && op_i == 4'd3) |=> (z_o == !$past(data_i[bit_idx_i]) && !wr_en_o)); // R3
    AST_STORE_KEEPS_C: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && (op_i == 4'd6 || op_i == 4'd7)) |=> (wr_en_o && c_o == $past(c_i))); // R5
    AST_CARRY_OPS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && op_i >= 4'd8) |=> (!wr_en_o && data_o == $past(data_i))); // R6

endmodule

// File: tb/bitop_unit_bench.sv
module bitop_unit_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [3:0] op_i = '0;
    logic [2:0] bit_idx_i = '0;
    logic [7:0] data_i = '0;
    logic       c_i = 1'b0;
    logic       z_i = 1'b0;
    logic       res_valid_o;
    logic [7:0] data_o;
    logic       wr_en_o;
    logic       c_o;
    logic       z_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;
    logic [7:0] last_data = '0;
    logic       last_c = 1'b0;
    logic       last_z = 1'b0;

    always #2 clk = ~clk;

    bitop_unit u_bitop_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .bit_idx_i(bit_idx_i), .data_i(data_i), .c_i(c_i), .z_i(z_i),
        .res_valid_o(res_valid_o), .data_o(data_o), .wr_en_o(wr_en_o),
        .c_o(c_o), .z_o(z_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [3:0] op);
        if (op <= 4'd2)       return "R2";
        else if (op == 4'd3)  return "R3";
        else if (op <= 4'd5)  return "R4";
        else if (op <= 4'd7)  return "R5";
        else if (op <= 4'd13) return "R6";
        else                  return "R7";
    endfunction

    // expected byte, write flag, carry, zero
    function automatic logic [10:0] model(input logic [3:0] op, input logic [2:0] k,
                                          input logic [7:0] d, input logic c, input logic z);
        logic [7:0] nd = d;
        logic       w = 1'b0;
        logic       nc = c;
        logic       nz = z;
        logic       b = d[k];
        logic       bb = op[0] ? ~d[k] : d[k];
        case (op)
            4'd0: begin nd[k] = 1'b1; w = 1'b1; end
            4'd1: begin nd[k] = 1'b0; w = 1'b1; end
            4'd2: begin nd[k] = ~b;   w = 1'b1; end
            4'd3: nz = (b == 1'b0);
            4'd4: nc = b;
            4'd5: nc = ~b;
            4'd6: begin nd[k] = c;  w = 1'b1; end
            4'd7: begin nd[k] = ~c; w = 1'b1; end
            4'd8, 4'd9:   nc = bb && c;
            4'd10, 4'd11: nc = bb || c;
            4'd12, 4'd13: nc = bb != c;
            default: ;
        endcase
        return {nd, w, nc, nz};
    endfunction

    task automatic check_result(input logic [3:0] op, input logic [2:0] k,
                                input logic [7:0] d, input logic c, input logic z);
        logic [10:0] e = model(op, k, d, c, z);
        string r = req_of(op);
        chk("R8", "res_valid", 32'(res_valid_o), 32'd1);
        chk(r, "data", 32'(data_o), 32'(e[10:3]));
        chk(r, "wr_en", 32'(wr_en_o), 32'(e[2]));
        chk(r, "c", 32'(c_o), 32'(e[1]));
        chk(r, "z", 32'(z_o), 32'(e[0]));
        last_data = e[10:3];
        last_c = e[1];
        last_z = e[0];
    endtask

    task automatic do_op(input logic [3:0] op, input logic [2:0] k,
                         input logic [7:0] d, input logic c, input logic z);
        @(negedge clk);
        // idle cycle before this request: nothing valid, last result held
        chk("R8", "idle res_valid", 32'(res_valid_o), 32'd0);
        chk("R8", "idle wr_en", 32'(wr_en_o), 32'd0);
        chk("R8", "held data", 32'(data_o), 32'(last_data));
        chk("R8", "held c", 32'(c_o), 32'(last_c));
        chk("R8", "held z", 32'(z_o), 32'(last_z));
        start_i = 1'b1; op_i = op; bit_idx_i = k; data_i = d; c_i = c; z_i = z;
        @(negedge clk);
        start_i = 1'b0;
        check_result(op, k, d, c, z);
    endtask

    task automatic do_pair(input logic [3:0] op0, input logic [2:0] k0, input logic [7:0] d0,
                           input logic [3:0] op1, input logic [2:0] k1, input logic [7:0] d1,
                           input logic c, input logic z);
        @(negedge clk);
        start_i = 1'b1; op_i = op0; bit_idx_i = k0; data_i = d0; c_i = c; z_i = z;
        @(negedge clk);
        check_result(op0, k0, d0, c, z);
        op_i = op1; bit_idx_i = k1; data_i = d1;
        @(negedge clk);
        start_i = 1'b0;
        check_result(op1, k1, d1, c, z);
        @(negedge clk);
        chk("R8", "after pair res_valid", 32'(res_valid_o), 32'd0);
        chk("R8", "after pair data held", 32'(data_o), 32'(last_data));
    endtask

    initial begin
        void'($urandom(32'h1bd4_0077));
        repeat (3) @(negedge clk);
        // R9: reset values
        chk("R9", "reset res_valid", 32'(res_valid_o), 32'd0);
        chk("R9", "reset wr_en", 32'(wr_en_o), 32'd0);
        chk("R9", "reset data", 32'(data_o), 32'd0);
        chk("R9", "reset c", 32'(c_o), 32'd0);
        chk("R9", "reset z", 32'(z_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", "post-reset res_valid", 32'(res_valid_o), 32'd0);

        // R1: each index on 0x00 and 0xFF with force/toggle
        for (int k = 0; k < 8; k++) begin
            do_op(4'd0, 3'(k), 8'h00, 1'b0, 1'b0);   // R1 R2 single bit set
            do_op(4'd1, 3'(k), 8'hFF, 1'b1, 1'b1);   // R1 R2 single bit cleared
            do_op(4'd2, 3'(k), 8'h5A, 1'b0, 1'b1);   // R2 toggle
            do_op(4'd3, 3'(k), 8'h00, 1'b1, 1'b0);   // R3 zero bit -> Z=1
            do_op(4'd3, 3'(k), 8'hFF, 1'b0, 1'b1);   // R3 one bit -> Z=0
        end
        // R4 / R5 / R6 directed, both carries
        for (int op = 4; op < 14; op++) begin
            for (int cc = 0; cc < 2; cc++) begin
                do_op(4'(op), 3'd7, 8'h80, cc[0], 1'b0);
                do_op(4'(op), 3'd0, 8'hFE, cc[0], 1'b1);
            end
        end
        // R7 reserved codes
        do_op(4'd14, 3'd3, 8'hC3, 1'b1, 1'b0);
        do_op(4'd15, 3'd4, 8'h3C, 1'b0, 1'b1);
        // R8 back-to-back pairs
        do_pair(4'd0, 3'd2, 8'h00, 4'd8, 3'd2, 8'h11, 1'b1, 1'b0);
        do_pair(4'd12, 3'd5, 8'h20, 4'd7, 3'd5, 8'hFF, 1'b1, 1'b1);

        // random mix
        for (int i = 0; i < 600; i++) begin
            do_op(4'($urandom), 3'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));
        end

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !done) begin
                done = 1'b1;
                checks++;
                errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

endmodule